// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Block Fetcher

This block fills one cache block after a miss. The block is four words, and the words are spread across four memory banks, so word i of every block sits in bank i. When a miss is accepted, the fetcher spends one cycle putting the block address on a shared address bus with a single read strobe. All four banks see that strobe and address together and start their slow reads in parallel. After the fixed bank latency, the fetcher captures all four words in one cycle. It then returns them over a one-word bus, one word per cycle, in bank order.

Only the return transfers are serialized, so a miss costs one address cycle, one bank latency, and one bus cycle per word: 1 + 25 + 3 + 1 = 30 cycles at the default latency. Without overlap, four full reads would be needed. A flag marks the final word of the block. A new miss is accepted at the earliest in the cycle that carries that final word.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `miss_ready` is 1, `ret_valid` is 0, `ret_last` is 0 and `bank_rd` is 0.
- R2: A miss is accepted at a rising edge where `miss_req` and `miss_ready` are both 1. In the next cycle `bank_rd` is 1 and `bank_addr` equals the accepted `miss_addr`.
- R3: `bank_rd` is high for exactly one cycle per accepted miss.
- R4: The word for bank b is taken from `bank_rdata[b*32 +: 32]` in the last of the BANK_LAT cycles that follow the address cycle. Data a bank presents in any other cycle does not reach `ret_data`.
- R5: The four words appear on `ret_data` with `ret_valid` = 1 in four consecutive cycles. `ret_idx` is 0, 1, 2, 3 in that order, and the word with index i is the one read from bank i at the block address.
- R6: `ret_last` is 1 only together with the word whose `ret_idx` is 3, and in no other cycle.
- R7: The word with `ret_last` appears in cycle 1 + BANK_LAT + 3 + 1, counting the address cycle as cycle 1. This is cycle 30 at the default latency.
- R8: While a fetch is in progress and its last word has not yet been placed on the bus, `miss_ready` is 0. A `miss_req` raised in that window is ignored: there is no further `bank_rd`, the returned block is unchanged, and the fetcher is idle with no pending read after the block ends.
- R9: A miss requested in the cycle that carries `ret_last` is accepted at that edge. Its address cycle follows immediately, and its block returns with the same penalty as any other miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_req | input | 1 | Miss request |
| miss_addr | input | ADDR_W (30) | Block address of the miss |
| miss_ready | output | 1 | Fetcher can accept a miss this cycle |
| bank_rd | output | 1 | Read strobe broadcast to all banks |
| bank_addr | output | ADDR_W (30) | Block address broadcast to all banks |
| bank_rdata | input | NBANKS*DATA_W (128) | Read data of all banks, bank b at bits b*32 upward |
| ret_valid | output | 1 | A block word is on the return bus |
| ret_data | output | DATA_W (32) | Returned word |
| ret_idx | output | 2 | Word index within the block (equals bank number) |
| ret_last | output | 1 | Final word of the block |

## Verification
The last word of one block and the acceptance of the next miss can fall in the same cycle. The bench provokes this by raising `miss_req` with a new address in exactly the cycle where it sees `ret_last`. It then checks three things:
- the old block completes intact;
- `bank_rd` with the new address appears in the very next cycle;
- the second block returns with the full 30-cycle penalty and correct data.

The bank models present their data for a single cycle only, so a capture that comes one cycle early or late shows up as wrong data.

// File: rtl/ilv_block_fetch.sv
`timescale 1ns/1ps
module ilv_block_fetch #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 30,
  parameter int NBANKS   = 4,
  parameter int BANK_LAT = 25,
  localparam int IDX_W   = $clog2(NBANKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_req,
  input  logic [ADDR_W-1:0]        miss_addr,
  output logic                     miss_ready,
  output logic                     bank_rd,
  output logic [ADDR_W-1:0]        bank_addr,
  input  logic [NBANKS*DATA_W-1:0] bank_rdata,
  output logic                     ret_valid,
  output logic [DATA_W-1:0]        ret_data,
  output logic [IDX_W-1:0]         ret_idx,
  output logic                     ret_last
);
  localparam int CNT_W   = $clog2(BANK_LAT + 1);
  localparam int PENALTY = 1 + BANK_LAT + (NBANKS - 1) + 1;
  localparam int PEN_W   = $clog2(PENALTY + 2);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BANK_LAT - 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NBANKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RET} st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wbuf [NBANKS];

  wire accept  = miss_req && miss_ready;
  wire cap_now = (state == S_WAIT) && (cnt == CNT_END);

  assign ret_valid  = (state == S_RET);
  assign ret_last   = ret_valid && (idx == IDX_END);
  assign ret_idx    = idx;
  assign ret_data   = wbuf[idx];
  assign miss_ready = (state == S_IDLE) || ret_last;
  assign bank_rd    = (state == S_SEND);
  assign bank_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      idx    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_SEND;
          addr_q <= miss_addr;
        end
        S_SEND: begin
          state <= S_WAIT;
          cnt   <= '0;
        end
        S_WAIT: if (cap_now) begin
          state <= S_RET;
          idx   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (idx == IDX_END) begin
          if (accept) begin
            state  <= S_SEND;
            addr_q <= miss_addr;
          end else begin
            state <= S_IDLE;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      endcase
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_cap
    always_ff @(posedge clk) begin
      if (cap_now) wbuf[b] <= bank_rdata[b*DATA_W +: DATA_W];
    end
  end

  logic [PEN_W-1:0] pen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                pen_q <= '0;
    else if (accept)           pen_q <= PEN_W'(1);
    else if (state != S_IDLE)  pen_q <= pen_q + 1'b1;
  end

  // R2
  acc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bank_rd && bank_addr == $past(miss_addr));
  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |=> !bank_rd);
  // R5
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_last |=> ret_valid && ret_idx == IDX_W'($past(ret_idx) + 1'b1));
  // R5
  first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_valid) |-> ret_idx == '0);
  // R6
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_last |-> ret_valid && ret_idx == IDX_END);
  // R7
  penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_last |-> pen_q == PEN_W'(PENALTY));
  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_last |-> !miss_ready);
  // R8
  no_rd_during_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |-> !ret_valid && !miss_ready);
endmodule

// File: tb/ilv_block_fetch_tb.sv
`timescale 1ns/1ps
module ilv_block_fetch_tb;
  localparam int DW = 32, AW = 30, NB = 4, LAT = 25;
  localparam int PEN = 1 + LAT + 3 + 1;

  logic clk = 0, rst_n = 0;
  logic miss_req = 0;
  logic [AW-1:0] miss_addr = '0;
  logic miss_ready, bank_rd, ret_valid, ret_last;
  logic [AW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_rdata;
  logic [DW-1:0] ret_data;
  logic [1:0] ret_idx;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ilv_block_fetch #(.DATA_W(DW), .ADDR_W(AW), .NBANKS(NB), .BANK_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .bank_rd(bank_rd), .bank_addr(bank_addr),
    .bank_rdata(bank_rdata), .ret_valid(ret_valid), .ret_data(ret_data),
    .ret_idx(ret_idx), .ret_last(ret_last));

  function automatic logic [DW-1:0] expw(input logic [AW-1:0] a, input int b);
    return {a, 2'(b)} ^ 32'h5A3C_96E1;
  endfunction

  // bank models: data valid for exactly one cycle, LAT cycles after the strobe
  logic [7:0]    bcnt;
  logic          bbusy;
  logic [AW-1:0] baddr;
  always @(posedge clk) begin
    bank_rdata <= {NB{32'hDEAD_BEEF}};
    if (!rst_n) begin
      bbusy <= 0; bcnt <= 0; baddr <= '0;
    end else if (bank_rd) begin
      bbusy <= 1; bcnt <= 8'd1; baddr <= bank_addr;
    end else if (bbusy) begin
      if (bcnt == 8'(LAT - 1)) begin
        bbusy <= 0;
        for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] <= expw(baddr, b);
      end else bcnt <= bcnt + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at the negedge of cycle 1 (address cycle). Returns at the negedge carrying ret_last.
  task automatic follow(input logic [AW-1:0] a, input bit poke, input bit chain,
                        input logic [AW-1:0] nxt);
    int n = 1, got = 0;
    forever begin
      if (n == 1) begin
        chk(bank_rd == 1, "R2 bank_rd in address cycle", bank_rd, 1);
        chk(bank_addr == a, "R2 bank_addr", bank_addr, a);
      end else if (bank_rd) chk(0, "R3 extra bank_rd", n, 1);
      if (poke && n == 5) begin miss_req = 1; miss_addr = ~a; end
      if (poke && n == 6) miss_req = 0;
      if (!ret_last && miss_ready) chk(0, "R8 ready while busy", n, 0);
      if (ret_valid) begin
        chk(ret_idx == 2'(got), "R5 word order", ret_idx, got);
        chk(ret_data == expw(a, got), "R5 R4 word data", ret_data, expw(a, got));
        if (!ret_last && got == 3) chk(0, "R6 missing last", got, 3);
        got++;
      end
      if (ret_last) begin
        chk(got == 4, "R6 last with fourth word", got, 4);
        chk(n == PEN, "R7 miss penalty", n, PEN);
        if (chain) begin
          chk(miss_ready == 1, "R9 ready with last word", miss_ready, 1);
          miss_req = 1; miss_addr = nxt;
        end
        return;
      end
      if (ret_valid && got > 0 && n > PEN) begin chk(0, "R7 late", n, PEN); return; end
      if (n > PEN + 10) begin chk(0, "R7 no last word", n, PEN); return; end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(miss_ready == 1, "R1 ready after reset", miss_ready, 1);
    chk(ret_valid == 0, "R1 valid after reset", ret_valid, 0);
    chk(ret_last == 0, "R1 last after reset", ret_last, 0);
    chk(bank_rd == 0, "R1 bank_rd after reset", bank_rd, 0);
  endtask

  task automatic t_single(input logic [AW-1:0] a);
    @(negedge clk);
    chk(miss_ready == 1, "R2 ready before miss", miss_ready, 1);
    miss_req = 1; miss_addr = a;
    @(negedge clk);
    miss_req = 0;
    follow(a, 0, 0, '0);
    @(negedge clk);
    chk(ret_valid == 0 && miss_ready == 1, "R6 idle after block", ret_valid, 0);
  endtask

  task automatic t_busy_ignored(input logic [AW-1:0] a);
    @(negedge clk);
    miss_req = 1; miss_addr = a;
    @(negedge clk);
    miss_req = 0;
    follow(a, 1, 0, '0);
    @(negedge clk);
    chk(bank_rd == 0, "R8 ignored miss not queued", bank_rd, 0);
    chk(miss_ready == 1 && ret_valid == 0, "R8 idle after block", ret_valid, 0);
    repeat (3) @(negedge clk);
    chk(bank_rd == 0 && ret_valid == 0, "R8 still idle", bank_rd, 0);
  endtask

  task automatic t_overlap(input logic [AW-1:0] a, input logic [AW-1:0] b);
    @(negedge clk);
    miss_req = 1; miss_addr = a;
    @(negedge clk);
    miss_req = 0;
    follow(a, 0, 1, b);
    @(negedge clk);
    miss_req = 0;
    chk(bank_rd == 1, "R9 address cycle right after last", bank_rd, 1);
    follow(b, 0, 0, '0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_single(30'h0000_0000);
    t_single(30'h3FFF_FFFF);
    t_single(30'h1234_5678);
    t_busy_ignored(30'h0ABC_DEF0);
    t_overlap(30'h0000_0011, 30'h2222_3333);
    t_single(30'h0000_0001);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule